// File: doc/BRIEF.md
# Triple-Sensor Temperature Rationalizer

This block receives three readings of one physical temperature point on every sample strobe. The first comes from a sensor wired straight to this logic; the other two, relay A and relay B, arrive over other paths. Each reading is classified on its own. A reading outside fixed absolute bounds points to an open or shorted sensor and is called insane. A reading that stands above both of its peers by more than a programmable drift threshold is called drifted. From the readings that are neither insane nor drifted, the block picks one trusted temperature.

The direct reading wins whenever it is clean. Otherwise relay A is used, then relay B. When all three are faulty, the trusted-data flag drops and the last trusted temperature is held. A separate over-range flag is raised only when at least two sane readings agree that the point is above the over-range limit, so one sensor running high cannot raise it alone. All outputs are registered and change one clock after a sample strobe. Between strobes they hold.

Top module: `trisense_rationalizer`

## Requirements
- R1: `out_strobe` is high for exactly the one clock cycle that follows each cycle with `smp_valid` high, and is low otherwise.
- R2: A reading is insane when it is above `HI_LIMIT` or below `LO_LIMIT`. A value equal to either limit is sane. `insane_flags` bit 0 is the direct reading, bit 1 is relay A and bit 2 is relay B.
- R3: `src_sel` gives the first faulty-free channel in the order direct (0), relay A (1), relay B (2). It reads 3 when none is clean. A channel is faulty when it is insane or drifted.
- R4: When a clean channel exists, `temp_out` equals that channel's reading from the same sample and `temp_ok` is 1.
- R5: A reading is drifted when it exceeds each of the other two readings by strictly more than `drift_thr`. Exceeding only one peer, or exceeding by exactly `drift_thr`, is not drift. `drift_flags` uses the same bit order as R2.
- R6: `over_conf` is 1 exactly when at least two readings lie above `OVR_LIMIT` and no higher than `HI_LIMIT`.
- R7: When all three channels are faulty, `temp_ok` is 0, `src_sel` is 3 and `temp_out` keeps its previous value.
- R8: After reset, `temp_out` is 0, `temp_ok` is 0, `src_sel` is 3, and all flags and the strobe are 0.
- R9: Fault flags are recomputed on every sample and are never latched. A channel flagged on one sample is clear on the next if its reading is good.
- R10: Input changes without `smp_valid` leave every output except `out_strobe` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | New sample set present on the reading inputs |
| t_direct | input | TW | Directly sensed reading |
| t_relay_a | input | TW | First relayed reading |
| t_relay_b | input | TW | Second relayed reading |
| drift_thr | input | TW | Drift threshold against peers |
| temp_out | output | TW | Trusted temperature |
| temp_ok | output | 1 | Trusted temperature comes from the current sample |
| src_sel | output | 2 | Chosen channel: 0 direct, 1 relay A, 2 relay B, 3 none |
| insane_flags | output | 3 | Out-of-bounds flag per channel |
| drift_flags | output | 3 | Drift flag per channel |
| over_conf | output | 1 | Over-range confirmed by two sane readings |
| out_strobe | output | 1 | Outputs updated this cycle |

## Verification
The bench drives readings that sit exactly on `LO_LIMIT` and `HI_LIMIT` and one step past them. A design that used the wrong comparison there would flag healthy sensors or miss shorts. It sets drift margins equal to the threshold, one above it, and above only a single peer. An off-by-one or an OR in place of an AND would then show up as a wrong fallback channel. It walks the fallback order through every fault combination, including all three faulty. A design that cleared or overwrote the held temperature there would show a changed `temp_out`. Over-range is tested with one high sensor, two high sensors, and high sensors that are also insane, to catch confirmation from a single reading.

// File: rtl/trs_pkg.sv
package trs_pkg;
   localparam int NCH = 3;
   typedef enum logic [1:0] {
      SRC_DIRECT  = 2'd0,
      SRC_RELAY_A = 2'd1,
      SRC_RELAY_B = 2'd2,
      SRC_NONE    = 2'd3
   } src_e;
endpackage

// File: rtl/trs_bounds_check.sv
module trs_bounds_check #(
   parameter int TW        = 12,
   parameter int LO_LIMIT  = 100,
   parameter int HI_LIMIT  = 3900,
   parameter int OVR_LIMIT = 2000
) (
   input  logic [TW-1:0] reading,
   output logic          insane,
   output logic          hot
);
   localparam logic [TW-1:0] LO_V  = TW'(LO_LIMIT);
   localparam logic [TW-1:0] HI_V  = TW'(HI_LIMIT);
   localparam logic [TW-1:0] OVR_V = TW'(OVR_LIMIT);

   always_comb begin
      insane = (reading > HI_V) || (reading < LO_V);
      // hot: above over-range yet still within the sane window
      hot    = (reading > OVR_V) && (reading <= HI_V);
   end
endmodule

// File: rtl/trs_drift_check.sv
module trs_drift_check #(
   parameter int TW        = 12,
   parameter bit INCLUSIVE = 1'b0
) (
   input  logic [TW-1:0] self_v,
   input  logic [TW-1:0] peer0,
   input  logic [TW-1:0] peer1,
   input  logic [TW-1:0] thr,
   output logic          drift
);
   localparam int EW = TW + 1;
   logic [EW-1:0] s_ext, lim0, lim1;

   always_comb begin
      s_ext = {1'b0, self_v};
      lim0  = {1'b0, peer0} + {1'b0, thr};
      lim1  = {1'b0, peer1} + {1'b0, thr};
   end

   generate
      if (INCLUSIVE) begin : g_incl
         assign drift = (s_ext >= lim0) && (s_ext >= lim1);
      end else begin : g_strict
         assign drift = (s_ext > lim0) && (s_ext > lim1);
      end
   endgenerate
endmodule

// File: rtl/trs_select.sv
module trs_select
   import trs_pkg::*;
#(
   parameter int TW = 12
) (
   input  logic [NCH-1:0][TW-1:0] vals,
   input  logic [NCH-1:0]         fault,
   output src_e                   sel,
   output logic [TW-1:0]          sel_val,
   output logic                   any_ok
);
   always_comb begin
      sel     = SRC_NONE;
      sel_val = '0;
      any_ok  = 1'b0;
      // scan from lowest priority upward so the highest-priority clean channel wins
      for (int i = NCH - 1; i >= 0; i--) begin
         if (!fault[i]) begin
            sel     = src_e'(2'(i));
            sel_val = vals[i];
            any_ok  = 1'b1;
         end
      end
   end

   // R3: a chosen channel is never one flagged faulty
   always_comb begin
      if (any_ok) begin
         a_sel_clean_r3: assert (!fault[sel]);
      end
   end
endmodule

// File: rtl/trisense_rationalizer.sv
module trisense_rationalizer
   import trs_pkg::*;
#(
   parameter int TW           = 12,
   parameter int LO_LIMIT     = 100,
   parameter int HI_LIMIT     = 3900,
   parameter int OVR_LIMIT    = 2000,
   parameter bit DRIFT_INCLUSIVE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_valid,
   input  logic [TW-1:0] t_direct,
   input  logic [TW-1:0] t_relay_a,
   input  logic [TW-1:0] t_relay_b,
   input  logic [TW-1:0] drift_thr,
   output logic [TW-1:0] temp_out,
   output logic          temp_ok,
   output logic [1:0]    src_sel,
   output logic [2:0]    insane_flags,
   output logic [2:0]    drift_flags,
   output logic          over_conf,
   output logic          out_strobe
);
   localparam int CW = $clog2(NCH + 1);

   generate
      if (TW < 4) begin : g_bad_tw
         $error("trisense_rationalizer: TW too small");
      end
      if (!(LO_LIMIT < OVR_LIMIT && OVR_LIMIT < HI_LIMIT)) begin : g_bad_order
         $error("trisense_rationalizer: limits must satisfy LO < OVR < HI");
      end
      if (HI_LIMIT >= (1 << TW)) begin : g_bad_hi
         $error("trisense_rationalizer: HI_LIMIT does not fit TW");
      end
   endgenerate

   logic [NCH-1:0][TW-1:0] vals;
   logic [NCH-1:0]         ins_c, hot_c, drf_c, fault_c;
   src_e                   sel_c;
   logic [TW-1:0]          sel_val_c;
   logic                   any_ok_c;
   logic [CW-1:0]          hot_cnt;

   assign vals[0] = t_direct;
   assign vals[1] = t_relay_a;
   assign vals[2] = t_relay_b;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      trs_bounds_check #(
         .TW(TW), .LO_LIMIT(LO_LIMIT), .HI_LIMIT(HI_LIMIT), .OVR_LIMIT(OVR_LIMIT)
      ) u_bounds (
         .reading(vals[g]),
         .insane (ins_c[g]),
         .hot    (hot_c[g])
      );
      trs_drift_check #(.TW(TW), .INCLUSIVE(DRIFT_INCLUSIVE)) u_drift (
         .self_v(vals[g]),
         .peer0 (vals[(g + 1) % NCH]),
         .peer1 (vals[(g + 2) % NCH]),
         .thr   (drift_thr),
         .drift (drf_c[g])
      );
      assign fault_c[g] = ins_c[g] | drf_c[g];
   end

   trs_select #(.TW(TW)) u_sel (
      .vals   (vals),
      .fault  (fault_c),
      .sel    (sel_c),
      .sel_val(sel_val_c),
      .any_ok (any_ok_c)
   );

   always_comb begin
      hot_cnt = '0;
      for (int i = 0; i < NCH; i++) hot_cnt = hot_cnt + CW'(hot_c[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         temp_out     <= '0;
         temp_ok      <= 1'b0;
         src_sel      <= SRC_NONE;
         insane_flags <= '0;
         drift_flags  <= '0;
         over_conf    <= 1'b0;
         out_strobe   <= 1'b0;
      end else begin
         out_strobe <= smp_valid;
         if (smp_valid) begin
            insane_flags <= ins_c;
            drift_flags  <= drf_c;
            src_sel      <= sel_c;
            temp_ok      <= any_ok_c;
            over_conf    <= (hot_cnt >= CW'(2));
            if (any_ok_c) temp_out <= sel_val_c;
         end
      end
   end

   // R1: each sample yields a strobe on the following cycle
   p_strobe_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> out_strobe);

   // R3: clean direct channel is always the one reported
   p_direct_pref_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_strobe && !insane_flags[0] && !drift_flags[0] |-> src_sel == 2'd0);

   // R7: with nothing trusted, the temperature is held
   p_hold_when_lost_r7: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid && !any_ok_c |=> $stable(temp_out) && !temp_ok && src_sel == 2'd3);

   // R6: confirmation implies a trusted reading exists
   p_over_needs_trust_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_strobe && over_conf |-> temp_ok);

   // R10: outputs are quiet between samples
   p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(temp_out) && $stable(src_sel) && $stable(insane_flags)
                     && $stable(drift_flags) && $stable(over_conf) && $stable(temp_ok));
endmodule

// File: tb/trisense_rationalizer_test.sv
module trisense_rationalizer_test;
   localparam int TW  = 12;
   localparam int LO  = 100;
   localparam int HI  = 3900;
   localparam int OVR = 2000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [TW-1:0] t_direct = '0, t_relay_a = '0, t_relay_b = '0, drift_thr = '0;
   logic [TW-1:0] temp_out;
   logic          temp_ok, over_conf, out_strobe;
   logic [1:0]    src_sel;
   logic [2:0]    insane_flags, drift_flags;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   trisense_rationalizer #(.TW(TW), .LO_LIMIT(LO), .HI_LIMIT(HI), .OVR_LIMIT(OVR)) uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .t_direct(t_direct), .t_relay_a(t_relay_a), .t_relay_b(t_relay_b),
      .drift_thr(drift_thr), .temp_out(temp_out), .temp_ok(temp_ok),
      .src_sel(src_sel), .insane_flags(insane_flags), .drift_flags(drift_flags),
      .over_conf(over_conf), .out_strobe(out_strobe)
   );

   // behavioural reference model
   int e_temp = 0, e_ok = 0, e_sel = 3, e_ins = 0, e_drf = 0, e_over = 0, e_strb = 0;

   always @(posedge clk) begin
      int v[3];
      int ins, drf, hotn, sel;
      if (!rst_n) begin
         e_temp = 0; e_ok = 0; e_sel = 3; e_ins = 0; e_drf = 0; e_over = 0; e_strb = 0;
      end else begin
         e_strb = smp_valid;
         if (smp_valid) begin
            v[0] = t_direct; v[1] = t_relay_a; v[2] = t_relay_b;
            ins = 0; drf = 0; hotn = 0; sel = 3;
            for (int i = 0; i < 3; i++) begin
               if (v[i] > HI || v[i] < LO) ins |= (1 << i);
               if (v[i] > v[(i+1)%3] + int'(drift_thr) && v[i] > v[(i+2)%3] + int'(drift_thr))
                  drf |= (1 << i);
               if (v[i] > OVR && v[i] <= HI) hotn++;
            end
            for (int i = 2; i >= 0; i--)
               if (((ins | drf) & (1 << i)) == 0) sel = i;
            e_ins = ins; e_drf = drf; e_sel = sel;
            e_over = (hotn >= 2);
            e_ok = (sel != 3);
            if (sel != 3) e_temp = v[sel];
         end
      end
   end

   task automatic cmp(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every clock away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         cmp("R1 strobe", int'(out_strobe), e_strb);
         cmp("R2 insane", int'(insane_flags), e_ins);
         cmp("R5 drift", int'(drift_flags), e_drf);
         cmp("R3 select", int'(src_sel), e_sel);
         cmp("R4 temp", int'(temp_out), e_temp);
         cmp("R7 ok", int'(temp_ok), e_ok);
         cmp("R6 over", int'(over_conf), e_over);
      end
   end

   task automatic sample(input int d, input int a, input int b, input int th);
      t_direct = TW'(d); t_relay_a = TW'(a); t_relay_b = TW'(b); drift_thr = TW'(th);
      smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8 reset state
      cmp("R8 reset temp", int'(temp_out), 0);
      cmp("R8 reset sel", int'(src_sel), 3);
      cmp("R8 reset flags", int'({temp_ok, insane_flags, drift_flags, over_conf, out_strobe}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      sample(1500, 1510, 1490, 40);          // all clean
      cmp("R3 direct chosen", int'(src_sel), 0);
      cmp("R4 direct value", int'(temp_out), 1500);
      sample(4000, 1510, 1490, 40);          // direct open
      cmp("R2 direct above hi", int'(insane_flags), 1);
      cmp("R3 fallback relay A", int'(src_sel), 1);
      sample(50, 1510, 1490, 40);            // direct short
      cmp("R2 direct below lo", int'(insane_flags), 1);
      sample(HI, LO, 1500, 4000);            // exact limits sane
      cmp("R2 limits sane", int'(insane_flags), 0);
      sample(HI + 1, LO - 1, 1500, 4000);
      cmp("R2 one past limits", int'(insane_flags), 3);
      cmp("R3 relay B chosen", int'(src_sel), 2);
      sample(1540, 1500, 1500, 40);          // exactly threshold
      cmp("R5 equal margin not drift", int'(drift_flags), 0);
      sample(1541, 1500, 1500, 40);
      cmp("R5 margin plus one drifts", int'(drift_flags), 1);
      cmp("R3 drift fallback", int'(src_sel), 1);
      cmp("R9 flags recomputed", int'(insane_flags), 0);
      sample(1600, 1590, 1500, 40);          // exceeds only one peer
      cmp("R5 single peer not drift", int'(drift_flags), 0);
      sample(1234, 1300, 1290, 40);
      sample(4095, 20, 4001, 40);            // all faulty
      cmp("R7 lost valid", int'(temp_ok), 0);
      cmp("R7 sel none", int'(src_sel), 3);
      cmp("R7 temp held", int'(temp_out), 1234);
      sample(1500, 1500, 1500, 10);
      cmp("R9 recovered", int'({insane_flags, drift_flags}), 0);
      sample(2500, 1500, 1500, 4000);        // single hot
      cmp("R6 one hot no confirm", int'(over_conf), 0);
      sample(2500, 2600, 1500, 4000);
      cmp("R6 two hot confirm", int'(over_conf), 1);
      sample(2500, 3950, 3990, 4000);        // hot pair insane
      cmp("R6 insane not counted", int'(over_conf), 0);
      // R10: inputs move without strobe
      t_direct = 12'd10; t_relay_a = 12'd3000; t_relay_b = 12'd3100;
      repeat (3) @(negedge clk);
      cmp("R10 idle temp", int'(temp_out), 2500);
      cmp("R10 idle sel", int'(src_sel), 0);
      cmp("R1 no strobe idle", int'(out_strobe), 0);

      for (int n = 0; n < 400; n++) begin
         int base;
         base = $urandom_range(300, 3700);
         sample(($urandom_range(0, 9) == 0) ? $urandom_range(0, 4095) : base + $urandom_range(0, 80) - 40,
                ($urandom_range(0, 9) == 0) ? $urandom_range(0, 4095) : base + $urandom_range(0, 80) - 40,
                ($urandom_range(0, 9) == 0) ? $urandom_range(0, 4095) : base + $urandom_range(0, 80) - 40,
                $urandom_range(0, 60));
         if (n % 7 == 0) @(negedge clk);
      end
      @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule